// File: doc/BRIEF.md
# Memory Error Logging and Threshold Unit

This unit sits beside the memory protection logic and keeps a software-visible record of read faults. Four requesters can report an uncorrectable fault: a CPU, a DMA engine, a coprocessor and a shared communication RAM. The first three can also report a correctable fault. Each report is a one-cycle strobe that comes with the faulting address. The unit keeps a sticky flag for every source and class, and it latches the last faulting address for each source that has a capture register. It also counts correctable faults and compares the count against a programmable limit. When the limit is reached it raises a flag that can drive an interrupt.

Software reaches the unit through a single-cycle register port. Reads are combinational and writes take effect at the clock edge. Flags are read-only. Software changes them through separate write-one-to-set and write-one-to-clear aliases. Configuration writes are accepted only while the write-protection enable input is high. The uncorrectable interrupt is the OR of the uncorrectable flags. The correctable interrupt is the threshold flag qualified by an enable bit, delayed by one register.

Top module: `mem_err_log`

## Requirements
- R1: After reset, every register reads 0 and both `unc_irq` and `cor_irq` are 0.
- R2: A strobe on `unc_err[i]` or `cor_err[i]` sets its flag. The flag reads 1 from the next cycle and stays set until software clears it. Uncorrectable flags sit at offset 00h: CPU bit 0, DMA bit 1, coprocessor bit 2, shared RAM bit 4; bit 3 and bits 31:5 read 0. Correctable flags sit at offset 20h: CPU bit 0, DMA bit 1, coprocessor bit 2; all other bits read 0.
- R3: Writing 1 to a bit of 02h or 22h sets the matching flag, and writing 1 to a bit of 04h or 24h clears it. Bits written 0 do nothing, and these four offsets always read 0. A hardware strobe in the same cycle as a software clear leaves the flag set.
- R4: Each capture register loads its source's address on that source's strobe and is readable from the next cycle; sources update independently. Uncorrectable captures: CPU 06h, DMA 08h, coprocessor 0Ah, shared RAM 0Eh. Correctable captures: CPU 26h, coprocessor 2Ah.
- R5: The counter at 2Eh (bits 15:0) adds the number of correctable strobes seen in a cycle and saturates at FFFFh. Software can write it without the write-protection enable; such a write takes priority over a strobe in the same cycle.
- R6: The threshold flag (bit 0 of 32h) sets when a cycle with a counted correctable strobe leaves the count greater than or equal to the threshold (bits 15:0 of 30h). Writing 1 to bit 0 of 34h clears it and writing 1 to bit 0 of 36h sets it. A counted strobe in the same cycle as a clear keeps it set.
- R7: `cor_irq` equals the threshold flag ANDed with the enable bit (bit 0 of 38h), as it stood one cycle earlier.
- R8: `unc_irq` is 1 exactly when at least one uncorrectable flag is set.
- R9: Writes to 02h, 04h, 22h, 24h, 30h, 34h, 36h and 38h take effect only while `wr_unlock` is 1. A blocked write changes nothing.
- R10: Offsets not listed above read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| wr_unlock | input | 1 | Write-protection enable for the guarded registers |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| unc_err | input | 4 | Uncorrectable fault strobes: CPU, DMA, coprocessor, shared RAM (bits 0 to 3) |
| unc_addr | input | 128 | Faulting addresses, 32 bits per uncorrectable source, source i in slice i |
| cor_err | input | 3 | Correctable fault strobes: CPU, DMA, coprocessor (bits 0 to 2) |
| cor_addr | input | 64 | Correctable faulting addresses: CPU in bits 31:0, coprocessor in bits 63:32 |
| unc_irq | output | 1 | Uncorrectable interrupt |
| cor_irq | output | 1 | Registered correctable-threshold interrupt |

## Verification
A flag, capture or counter register holding the wrong value shows up on the first read of its offset after the cycle that should have changed it, because every state element can be read back directly. A wrong uncorrectable flag also shows on `unc_irq` in that same cycle. A wrong threshold flag or enable bit shows on `cor_irq` one cycle later. The directed cases therefore read back right after each simultaneous-event corner: a clear racing a strobe, a counter write racing a strobe, and saturation. They also check `cor_irq` in the cycle before and the cycle after it is due to change.

// File: rtl/mel_pkg.sv
package mel_pkg;
    localparam int DW   = 32;
    localparam int OFS_W = 8;
    localparam int NUNC = 4;
    localparam int NCOR = 3;

    localparam logic [OFS_W-1:0] OFS_UFLG     = 8'h00;
    localparam logic [OFS_W-1:0] OFS_USET     = 8'h02;
    localparam logic [OFS_W-1:0] OFS_UCLR     = 8'h04;
    localparam logic [OFS_W-1:0] OFS_UADR_CPU = 8'h06;
    localparam logic [OFS_W-1:0] OFS_UADR_DMA = 8'h08;
    localparam logic [OFS_W-1:0] OFS_UADR_COP = 8'h0A;
    localparam logic [OFS_W-1:0] OFS_UADR_SHR = 8'h0E;
    localparam logic [OFS_W-1:0] OFS_CFLG     = 8'h20;
    localparam logic [OFS_W-1:0] OFS_CSET     = 8'h22;
    localparam logic [OFS_W-1:0] OFS_CCLR     = 8'h24;
    localparam logic [OFS_W-1:0] OFS_CADR_CPU = 8'h26;
    localparam logic [OFS_W-1:0] OFS_CADR_COP = 8'h2A;
    localparam logic [OFS_W-1:0] OFS_CCNT     = 8'h2E;
    localparam logic [OFS_W-1:0] OFS_CTHR     = 8'h30;
    localparam logic [OFS_W-1:0] OFS_CIFLG    = 8'h32;
    localparam logic [OFS_W-1:0] OFS_CICLR    = 8'h34;
    localparam logic [OFS_W-1:0] OFS_CISET    = 8'h36;
    localparam logic [OFS_W-1:0] OFS_CIEN     = 8'h38;

    // Uncorrectable source i -> register bit; the shared RAM skips bit 3.
    function automatic logic [DW-1:0] pack_unc(input logic [NUNC-1:0] f);
        logic [DW-1:0] w;
        w      = '0;
        w[2:0] = f[2:0];
        w[4]   = f[3];
        return w;
    endfunction

    function automatic logic [NUNC-1:0] unpack_unc(input logic [DW-1:0] w);
        return {w[4], w[2:0]};
    endfunction
endpackage

// File: rtl/mel_flag_bank.sv
module mel_flag_bank #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] hw_set,
    input  logic [N-1:0] sw_set,
    input  logic [N-1:0] sw_clr,
    output logic [N-1:0] flags
);
    typedef struct packed {
        logic [N-1:0] flg;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        // hardware and software sets both dominate a clear
        s_d.flg = (s_q.flg & ~sw_clr) | sw_set | hw_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign flags = s_q.flg;

    // R3
    hw_over_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|hw_set) |=> ((flags & $past(hw_set)) == $past(hw_set)));

    // R2
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_set == '0 && sw_set == '0 && sw_clr == '0) |=> $stable(flags));
endmodule

// File: rtl/mel_addr_cap.sv
module mel_addr_cap #(
    parameter int N  = 4,
    parameter int AW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    err,
    input  logic [N*AW-1:0] addr,
    output logic [N*AW-1:0] cap
);
    typedef struct packed {
        logic [N*AW-1:0] a;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        for (int i = 0; i < N; i++) begin
            if (err[i]) s_d.a[i*AW +: AW] = addr[i*AW +: AW];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cap = s_q.a;

    for (genvar g = 0; g < N; g++) begin : g_chk
        // R4
        cap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            err[g] |=> (cap[g*AW +: AW] == $past(addr[g*AW +: AW])));
    end
endmodule

// File: rtl/mel_cor_ctr.sv
module mel_cor_ctr #(
    parameter int CW  = 16,
    parameter int NEV = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NEV-1:0] ev,
    input  logic           cnt_we,
    input  logic [CW-1:0]  cnt_wdata,
    input  logic [CW-1:0]  thr,
    input  logic           flg_set_sw,
    input  logic           flg_clr_sw,
    input  logic           irq_en,
    output logic [CW-1:0]  cnt,
    output logic           flg,
    output logic           irq
);
    localparam int IW = $clog2(NEV + 1);
    localparam logic [CW-1:0] CMAX = '1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          flg;
        logic          irq;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        logic [IW-1:0] inc;
        logic [CW:0]   sum;
        logic          hw_hit;
        inc = '0;
        for (int i = 0; i < NEV; i++) inc = inc + IW'(ev[i]);
        sum = {1'b0, s_q.cnt} + (CW+1)'(inc);
        s_d = s_q;
        if (cnt_we)       s_d.cnt = cnt_wdata;
        else if (sum[CW]) s_d.cnt = CMAX;
        else              s_d.cnt = sum[CW-1:0];
        hw_hit  = (|ev) && !cnt_we && (s_d.cnt >= thr);
        s_d.flg = (s_q.flg && !flg_clr_sw) || flg_set_sw || hw_hit;
        s_d.irq = s_q.flg && irq_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt = s_q.cnt;
    assign flg = s_q.flg;
    assign irq = s_q.irq;

    // R5
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CMAX && !cnt_we) |=> (cnt == CMAX));

    // R6
    flg_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flg) |-> $past(flg_set_sw || (|ev)));
endmodule

// File: rtl/mem_err_log.sv
module mem_err_log
    import mel_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_unlock,
    input  logic               reg_wr_en,
    input  logic [7:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic [3:0]         unc_err,
    input  logic [4*AW-1:0]    unc_addr,
    input  logic [2:0]         cor_err,
    input  logic [2*AW-1:0]    cor_addr,
    output logic               unc_irq,
    output logic               cor_irq
);
    typedef struct packed {
        logic [CW-1:0] thr;
        logic          en;
    } cfg_t;

    cfg_t s_d, s_q;

    logic              wr_ok;
    logic [NUNC-1:0]   u_set, u_clr, u_flags;
    logic [NCOR-1:0]   c_set, c_clr, c_flags;
    logic              ci_set, ci_clr, ci_flg, cnt_we;
    logic [CW-1:0]     cnt;
    logic [NUNC*AW-1:0] u_cap;
    logic [2*AW-1:0]   c_cap;
    logic              wdata_unused;

    assign wdata_unused = ^reg_wdata;

    always_comb begin
        wr_ok  = reg_wr_en && wr_unlock;
        u_set  = (wr_ok && reg_addr == OFS_USET) ? unpack_unc(reg_wdata) : '0;
        u_clr  = (wr_ok && reg_addr == OFS_UCLR) ? unpack_unc(reg_wdata) : '0;
        c_set  = (wr_ok && reg_addr == OFS_CSET) ? reg_wdata[NCOR-1:0] : '0;
        c_clr  = (wr_ok && reg_addr == OFS_CCLR) ? reg_wdata[NCOR-1:0] : '0;
        ci_set = wr_ok && reg_addr == OFS_CISET && reg_wdata[0];
        ci_clr = wr_ok && reg_addr == OFS_CICLR && reg_wdata[0];
        cnt_we = reg_wr_en && reg_addr == OFS_CCNT;
        s_d    = s_q;
        if (wr_ok && reg_addr == OFS_CTHR) s_d.thr = reg_wdata[CW-1:0];
        if (wr_ok && reg_addr == OFS_CIEN) s_d.en  = reg_wdata[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    mel_flag_bank #(.N(NUNC)) i_unc_flags (
        .clk(clk), .rst_n(rst_n), .hw_set(unc_err),
        .sw_set(u_set), .sw_clr(u_clr), .flags(u_flags)
    );

    mel_flag_bank #(.N(NCOR)) i_cor_flags (
        .clk(clk), .rst_n(rst_n), .hw_set(cor_err),
        .sw_set(c_set), .sw_clr(c_clr), .flags(c_flags)
    );

    mel_addr_cap #(.N(NUNC), .AW(AW)) i_unc_cap (
        .clk(clk), .rst_n(rst_n), .err(unc_err), .addr(unc_addr), .cap(u_cap)
    );

    // correctable capture exists for CPU and coprocessor only
    mel_addr_cap #(.N(2), .AW(AW)) i_cor_cap (
        .clk(clk), .rst_n(rst_n), .err({cor_err[2], cor_err[0]}),
        .addr(cor_addr), .cap(c_cap)
    );

    mel_cor_ctr #(.CW(CW), .NEV(NCOR)) i_cor_ctr (
        .clk(clk), .rst_n(rst_n), .ev(cor_err), .cnt_we(cnt_we),
        .cnt_wdata(reg_wdata[CW-1:0]), .thr(s_q.thr),
        .flg_set_sw(ci_set), .flg_clr_sw(ci_clr), .irq_en(s_q.en),
        .cnt(cnt), .flg(ci_flg), .irq(cor_irq)
    );

    assign unc_irq = |u_flags;

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_UFLG:     reg_rdata = pack_unc(u_flags);
            OFS_CFLG:     reg_rdata[NCOR-1:0] = c_flags;
            OFS_UADR_CPU: reg_rdata[AW-1:0] = u_cap[0*AW +: AW];
            OFS_UADR_DMA: reg_rdata[AW-1:0] = u_cap[1*AW +: AW];
            OFS_UADR_COP: reg_rdata[AW-1:0] = u_cap[2*AW +: AW];
            OFS_UADR_SHR: reg_rdata[AW-1:0] = u_cap[3*AW +: AW];
            OFS_CADR_CPU: reg_rdata[AW-1:0] = c_cap[0*AW +: AW];
            OFS_CADR_COP: reg_rdata[AW-1:0] = c_cap[1*AW +: AW];
            OFS_CCNT:     reg_rdata[CW-1:0] = cnt;
            OFS_CTHR:     reg_rdata[CW-1:0] = s_q.thr;
            OFS_CIFLG:    reg_rdata[0] = ci_flg;
            OFS_CIEN:     reg_rdata[0] = s_q.en;
            default:      reg_rdata = '0;
        endcase
    end

    // R9
    locked_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && !wr_unlock) |=> ($stable(s_q.thr) && $stable(s_q.en)));

    // R7
    irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cor_irq |-> $past(s_q.en));
endmodule

// File: tb/test_mem_err_log.sv
module test_mem_err_log;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_unlock = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  unc_err = '0;
    logic [127:0] unc_addr = '0;
    logic [2:0]  cor_err = '0;
    logic [63:0] cor_addr = '0;
    logic        unc_irq, cor_irq;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    mem_err_log i_mem_err_log (
        .clk(clk), .rst_n(rst_n), .wr_unlock(wr_unlock), .reg_wr_en(reg_wr_en),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .unc_err(unc_err), .unc_addr(unc_addr), .cor_err(cor_err),
        .cor_addr(cor_addr), .unc_irq(unc_irq), .cor_irq(cor_irq)
    );

    typedef struct packed {
        logic        is_rd;
        logic        unl;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b0, 8'h00, 32'h0, 4'd1},          // R1 flags clear
        '{1'b1, 1'b0, 8'h2E, 32'h0, 4'd1},          // R1 counter clear
        '{1'b1, 1'b0, 8'h30, 32'h0, 4'd1},          // R1 threshold clear
        '{1'b0, 1'b1, 8'h02, 32'h1F, 4'd3},         // R3 set all, bit 3 ignored
        '{1'b1, 1'b0, 8'h00, 32'h17, 4'd2},         // R2 layout
        '{1'b1, 1'b0, 8'h02, 32'h0, 4'd3},          // R3 alias reads 0
        '{1'b0, 1'b1, 8'h04, 32'h05, 4'd3},         // R3 clear CPU, coprocessor
        '{1'b1, 1'b0, 8'h00, 32'h12, 4'd3},
        '{1'b1, 1'b0, 8'h04, 32'h0, 4'd3},
        '{1'b0, 1'b0, 8'h04, 32'h12, 4'd9},         // R9 blocked clear
        '{1'b1, 1'b0, 8'h00, 32'h12, 4'd9},
        '{1'b0, 1'b1, 8'h04, 32'h12, 4'd3},
        '{1'b1, 1'b0, 8'h00, 32'h0, 4'd3},
        '{1'b0, 1'b1, 8'h22, 32'hFF, 4'd3},         // R3 correctable set
        '{1'b1, 1'b0, 8'h20, 32'h7, 4'd2},
        '{1'b1, 1'b0, 8'h22, 32'h0, 4'd3},
        '{1'b0, 1'b1, 8'h30, 32'h1234ABCD, 4'd6},   // R6 threshold width
        '{1'b1, 1'b0, 8'h30, 32'hABCD, 4'd6},
        '{1'b0, 1'b0, 8'h2E, 32'h00050010, 4'd5},   // R5 unprotected count write
        '{1'b1, 1'b0, 8'h2E, 32'h10, 4'd5},
        '{1'b0, 1'b1, 8'h40, 32'hFFFF, 4'd10},      // R10 unlisted offset
        '{1'b1, 1'b0, 8'h40, 32'h0, 4'd10},
        '{1'b0, 1'b0, 8'h38, 32'h1, 4'd9},          // R9 blocked enable
        '{1'b1, 1'b0, 8'h38, 32'h0, 4'd9},
        '{1'b0, 1'b1, 8'h24, 32'h7, 4'd3},
        '{1'b1, 1'b0, 8'h20, 32'h0, 4'd3},
        '{1'b1, 1'b0, 8'h24, 32'h0, 4'd3}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic unl);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; wr_unlock = unl; reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0; wr_unlock = 1'b0;
    endtask

    task automatic pulse_u(input logic [3:0] e);
        @(negedge clk); unc_err = e;
        @(negedge clk); unc_err = '0;
    endtask

    task automatic pulse_c(input logic [2:0] e);
        @(negedge clk); cor_err = e;
        @(negedge clk); cor_err = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 unc_irq", {31'b0, unc_irq}, 32'h0);
        chk("R1 cor_irq", {31'b0, cor_irq}, 32'h0);

        for (int k = 0; k < NV; k++) begin
            if (VEC[k].is_rd)
                rd(VEC[k].addr, VEC[k].data, $sformatf("R%0d vec %0d", VEC[k].req, k));
            else
                wr(VEC[k].addr, VEC[k].data, VEC[k].unl);
        end

        // R8 R2 R4: shared RAM then CPU+DMA together
        unc_addr = {32'h0000_0ABC, 32'h3000_000C, 32'h2000_0008, 32'h1000_0004};
        pulse_u(4'b1000);
        #1 chk("R8 unc_irq up", {31'b0, unc_irq}, 32'h1);
        rd(8'h00, 32'h10, "R2 shared RAM bit4");
        rd(8'h0E, 32'h0000_0ABC, "R4 shared RAM capture");
        pulse_u(4'b0011);
        rd(8'h06, 32'h1000_0004, "R4 CPU capture");
        rd(8'h08, 32'h2000_0008, "R4 DMA capture");
        rd(8'h0A, 32'h0, "R4 coprocessor untouched");
        rd(8'h00, 32'h13, "R2 sticky");

        // R3: hardware strobe beats a simultaneous clear
        @(negedge clk);
        unc_err = 4'b0001; reg_addr = 8'h04; reg_wdata = 32'h1; wr_unlock = 1'b1; reg_wr_en = 1'b1;
        @(negedge clk);
        unc_err = '0; reg_wr_en = 1'b0; wr_unlock = 1'b0;
        rd(8'h00, 32'h13, "R3 strobe beats clear");
        wr(8'h04, 32'h17, 1'b1);
        rd(8'h00, 32'h0, "R3 clear all");
        #1 chk("R8 unc_irq down", {31'b0, unc_irq}, 32'h0);

        // R5 R6: counting against threshold 3
        wr(8'h30, 32'h3, 1'b1);
        wr(8'h2E, 32'h0, 1'b0);
        cor_addr = {32'hC0DE_0003, 32'hC0DE_0001};
        pulse_c(3'b011);
        rd(8'h2E, 32'h2, "R5 count two strobes");
        rd(8'h20, 32'h3, "R2 correctable flags");
        rd(8'h32, 32'h0, "R6 below threshold");
        rd(8'h26, 32'hC0DE_0001, "R4 correctable CPU capture");
        pulse_c(3'b100);
        rd(8'h32, 32'h1, "R6 reach threshold");
        rd(8'h2A, 32'hC0DE_0003, "R4 correctable coprocessor capture");
        #1 chk("R7 irq masked", {31'b0, cor_irq}, 32'h0);

        // R7: enable, irq one cycle later
        wr(8'h38, 32'h1, 1'b1);
        #1 chk("R7 irq not yet", {31'b0, cor_irq}, 32'h0);
        @(negedge clk); #1 chk("R7 irq asserted", {31'b0, cor_irq}, 32'h1);

        // R6: software clear and set of the threshold flag
        wr(8'h34, 32'h1, 1'b1);
        rd(8'h32, 32'h0, "R6 flag cleared");
        #1 chk("R7 irq dropped", {31'b0, cor_irq}, 32'h0);
        wr(8'h36, 32'h1, 1'b1);
        rd(8'h32, 32'h1, "R6 flag set by software");
        rd(8'h34, 32'h0, "R3 interrupt clear alias reads 0");
        @(negedge clk);
        cor_err = 3'b001; reg_addr = 8'h34; reg_wdata = 32'h1; wr_unlock = 1'b1; reg_wr_en = 1'b1;
        @(negedge clk);
        cor_err = '0; reg_wr_en = 1'b0; wr_unlock = 1'b0;
        rd(8'h32, 32'h1, "R6 strobe beats clear");
        rd(8'h2E, 32'h4, "R5 count four");

        // R5: saturation and write priority
        wr(8'h2E, 32'hFFFE, 1'b0);
        pulse_c(3'b111);
        rd(8'h2E, 32'hFFFF, "R5 saturate");
        pulse_c(3'b001);
        rd(8'h2E, 32'hFFFF, "R5 stay saturated");
        @(negedge clk);
        cor_err = 3'b001; reg_addr = 8'h2E; reg_wdata = 32'h7; reg_wr_en = 1'b1;
        @(negedge clk);
        cor_err = '0; reg_wr_en = 1'b0;
        rd(8'h2E, 32'h7, "R5 write beats strobe");

        // R1: reset mid-run
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        rd(8'h00, 32'h0, "R1 unc flags");
        rd(8'h20, 32'h0, "R1 cor flags");
        rd(8'h2E, 32'h0, "R1 counter");
        rd(8'h30, 32'h0, "R1 threshold");
        rd(8'h32, 32'h0, "R1 threshold flag");
        rd(8'h38, 32'h0, "R1 enable");
        rd(8'h06, 32'h0, "R1 capture");
        chk("R1 unc_irq after reset", {31'b0, unc_irq}, 32'h0);
        chk("R1 cor_irq after reset", {31'b0, cor_irq}, 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule